// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of page mappings that sits between a requester and memory. The requester presents a 32-bit virtual address. The upper 20 bits are the virtual page number and the lower 12 bits are the offset within a 4 KB page. Every valid entry compares its tag against the page number at the same time. On a match, the block returns a 20-bit physical address one cycle later. That address is the entry's 8-bit frame number placed above the offset, which passes through unchanged. The same hit marks the entry as recently used, and marks it as modified when the access is a write.

When no entry matches, the block does not translate. It reports a miss and raises a refill request that carries the missing page number. It then waits for the page-table entry to arrive on the refill port, and the requester retries the access. A refill that reports the page as absent is discarded and turns into a page-fault pulse. An installed entry goes into a free slot if there is one. Otherwise it replaces the lowest-numbered entry whose reference bit is clear. If every entry has been referenced, a rotating pointer chooses the victim.

A controller with two states sequences the work. In `ST_LOOKUP` the block accepts lookups. A lookup that misses takes the transition *miss* to `ST_REFILL`. In `ST_REFILL` the block holds its refill request and ignores lookups. When a refill arrives, it takes the transition *refill* back to `ST_LOOKUP`, installing the entry or flagging the fault. Two side inputs act on all entries in a single cycle: one clears every reference bit and one invalidates every entry.

Top module: `tlb_top`

## Requirements
- R1: A lookup presented in one cycle that hits raises `resp_hit` in the next cycle, with `resp_paddr` = {frame number, `req_vaddr[11:0]`}. The frame number is the 8-bit value that was installed for `req_vaddr[31:12]`.
- R2: A lookup that misses raises `resp_miss` for one cycle in the next cycle. From that cycle, `refill_req` stays high and `refill_vpn` holds the missing page number until `refill_valid` is seen. Lookups presented during that wait produce neither `resp_hit` nor `resp_miss`.
- R3: A refill with `refill_present` = 1 installs the entry, and a retry of the same page then hits with the supplied frame number.
- R4: A hit on a write (`req_write` = 1) sets the entry's dirty bit. `resp_dirty` reports the entry's dirty bit as it stands after the access, so a later read hit also reports 1. A newly installed entry starts clean.
- R5: A refill with `refill_present` = 0 installs nothing and raises `fault` for one cycle, in the cycle after `refill_valid`. A retry of that page misses again.
- R6: While any entry is invalid, a refill goes to the lowest-numbered invalid entry and evicts nothing, so `ENTRIES` distinct pages all stay resident after a flush.
- R7: A hit sets the entry's reference bit. When every entry is valid, a refill replaces the lowest-numbered entry whose reference bit is 0.
- R8: When every entry is valid and referenced, a refill replaces the entry at a rotating pointer. The pointer is 0 after reset and advances by one, with wrap, after each such replacement.
- R9: A one-cycle `clr_ref` pulse clears the reference bit of every entry.
- R10: A one-cycle `flush` pulse invalidates every entry, so every following lookup misses until refilled.
- R11: After reset, `resp_hit`, `resp_miss`, `refill_req` and `fault` are low, all entries are invalid, and the controller is in `ST_LOOKUP`.
- R12: The capacity is the parameter `ENTRIES`, default 16, with a lookup completing in one cycle for any capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_write | input | 1 | Lookup is for a write access |
| resp_hit | output | 1 | Previous-cycle lookup hit |
| resp_miss | output | 1 | Previous-cycle lookup missed |
| resp_paddr | output | 20 | Translated physical address, valid with `resp_hit` |
| resp_dirty | output | 1 | Dirty bit of the hit entry after the access |
| refill_req | output | 1 | Waiting for a page-table entry |
| refill_vpn | output | 20 | Page number to fetch |
| refill_valid | input | 1 | Page-table entry delivered |
| refill_pfn | input | 8 | Frame number of the delivered entry |
| refill_present | input | 1 | Delivered page is resident in memory |
| fault | output | 1 | Refill reported a non-resident page |
| clr_ref | input | 1 | Clear all reference bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Every response is registered once, so `resp_hit`, `resp_miss`, `resp_paddr` and `resp_dirty` belong to the lookup of the previous cycle. `refill_req` rises at the same edge as `resp_miss`, and `fault` follows `refill_valid` by one edge. The bench drives inputs on the falling edge and reads results on the next falling edge, which is exactly one rising edge later. Replacement order and reference clearing cannot be seen directly at the ports. They are observed through which pages later hit or miss, and a not-present refill lets the bench probe a page without disturbing the other entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 8;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
        logic             refd;
        logic             dirty;
    } tlb_entry_t;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } tlb_state_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  tlb_entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]         vpn,
    output logic [ENTRIES-1:0]       hit_vec,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].tag == vpn);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] ref_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               use_rr
);

    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] cold_vec;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   cold_idx;

    assign free_vec = ~valid_vec;
    assign cold_vec = valid_vec & ~ref_vec;

    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IDX_W'(i);
            if (cold_vec[i]) cold_idx = IDX_W'(i);
        end
        use_rr = 1'b0;
        if (|free_vec) begin
            victim = free_idx;
        end else if (|cold_vec) begin
            victim = cold_idx;
        end else begin
            victim = rr_ptr;
            use_rr = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       lookup_hit,
    input  logic       refill_valid,
    output tlb_state_t state,
    output logic       do_lookup,
    output logic       miss_take,
    output logic       refill_take
);

    tlb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        do_lookup   = 1'b0;
        miss_take   = 1'b0;
        refill_take = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                do_lookup = req_valid;
                if (req_valid && !lookup_hit) begin
                    miss_take = 1'b1;
                    state_d   = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (refill_valid) begin
                    refill_take = 1'b1;
                    state_d     = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic [19:0]      resp_paddr,
    output logic             resp_dirty,
    output logic             refill_req,
    output logic [19:0]      refill_vpn,
    input  logic             refill_valid,
    input  logic [7:0]       refill_pfn,
    input  logic             refill_present,
    output logic             fault,
    input  logic             clr_ref,
    input  logic             flush
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t [ENTRIES-1:0] ents_q, ents_d;
    logic [ENTRIES-1:0] valid_vec, ref_vec, hit_vec;
    logic [VPN_W-1:0]   req_vpn, miss_vpn;
    logic [OFF_W-1:0]   req_off;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx, victim, rr_ptr;
    logic               use_rr;
    tlb_state_t         state;
    logic               do_lookup, miss_take, refill_take, install;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign valid_vec[g] = ents_q[g].valid;
        assign ref_vec[g]   = ents_q[g].refd;
    end

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents    (ents_q),
        .vpn     (req_vpn),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_vec (valid_vec),
        .ref_vec   (ref_vec),
        .rr_ptr    (rr_ptr),
        .victim    (victim),
        .use_rr    (use_rr)
    );

    tlb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .lookup_hit   (hit),
        .refill_valid (refill_valid),
        .state        (state),
        .do_lookup    (do_lookup),
        .miss_take    (miss_take),
        .refill_take  (refill_take)
    );

    assign install = refill_take && refill_present && !flush;

    // Next-state of the entry array
    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (install && victim == IDX_W'(i)) begin
                ents_d[i].valid = 1'b1;
                ents_d[i].tag   = miss_vpn;
                ents_d[i].pfn   = refill_pfn;
                ents_d[i].refd  = 1'b0;
                ents_d[i].dirty = 1'b0;
            end
            if (do_lookup && hit && hit_idx == IDX_W'(i)) begin
                ents_d[i].refd = 1'b1;
                if (req_write) ents_d[i].dirty = 1'b1;
            end
            if (clr_ref) ents_d[i].refd  = 1'b0;
            if (flush)   ents_d[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ents_q <= '0;
        else        ents_q <= ents_d;
    end

    // Round-robin pointer and missing page latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr   <= '0;
            miss_vpn <= '0;
        end else begin
            if (miss_take) miss_vpn <= req_vpn;
            if (install && use_rr) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_paddr <= '0;
            resp_dirty <= 1'b0;
            fault      <= 1'b0;
        end else begin
            resp_hit   <= do_lookup && hit;
            resp_miss  <= miss_take;
            resp_paddr <= (do_lookup && hit) ? {ents_q[hit_idx].pfn, req_off} : '0;
            resp_dirty <= (do_lookup && hit) ? (ents_q[hit_idx].dirty || req_write) : 1'b0;
            fault      <= refill_take && !refill_present;
        end
    end

    assign refill_req = (state == ST_REFILL);
    assign refill_vpn = miss_vpn;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [31:0]        req_vaddr,
    input logic               req_write,
    input logic               resp_hit,
    input logic               resp_miss,
    input logic [19:0]        resp_paddr,
    input logic               resp_dirty,
    input logic               refill_req,
    input logic               refill_valid,
    input logic               refill_present,
    input logic               fault,
    input logic [ENTRIES-1:0] hit_vec
);

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> $past(req_valid) && !$past(refill_req)); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_paddr[11:0] == $past(req_vaddr[11:0])); // R1

    AST_MISS_RAISES_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> refill_req && !resp_hit); // R2

    AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !refill_valid |=> refill_req && !resp_hit && !resp_miss); // R2

    AST_REFILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && refill_valid |=> !refill_req); // R3

    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit && $past(req_write) |-> resp_dirty); // R4

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(refill_req && refill_valid && !refill_present)); // R5

    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R6

endmodule

bind tlb_top tlb_chk #(.ENTRIES(ENTRIES)) u_tlb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_write      (req_write),
    .resp_hit       (resp_hit),
    .resp_miss      (resp_miss),
    .resp_paddr     (resp_paddr),
    .resp_dirty     (resp_dirty),
    .refill_req     (refill_req),
    .refill_valid   (refill_valid),
    .refill_present (refill_present),
    .fault          (fault),
    .hit_vec        (hit_vec)
);

// File: tb/tb_tlb_top.sv
module tb_tlb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_vaddr;
    logic        resp_hit, resp_miss, resp_dirty;
    logic [19:0] resp_paddr;
    logic        refill_req;
    logic [19:0] refill_vpn;
    logic        refill_valid, refill_present;
    logic [7:0]  refill_pfn;
    logic        fault, clr_ref, flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tlb_top #(.ENTRIES(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_paddr(resp_paddr), .resp_dirty(resp_dirty), .refill_req(refill_req),
        .refill_vpn(refill_vpn), .refill_valid(refill_valid), .refill_pfn(refill_pfn),
        .refill_present(refill_present), .fault(fault), .clr_ref(clr_ref), .flush(flush)
    );

    // {vaddr, write, expect first attempt hit, expect dirty after}
    localparam int NVEC = 8;
    localparam logic [34:0] VEC [NVEC] = '{
        {32'h0000_1ABC, 1'b0, 1'b0, 1'b0},
        {32'h0000_1FFF, 1'b1, 1'b1, 1'b1},
        {32'h0000_1000, 1'b0, 1'b1, 1'b1},
        {32'hFFFF_F123, 1'b0, 1'b0, 1'b0},
        {32'hFFFF_F000, 1'b1, 1'b1, 1'b1},
        {32'h1234_5678, 1'b1, 1'b0, 1'b1},
        {32'h1234_5001, 1'b0, 1'b1, 1'b1},
        {32'h0000_2ABC, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [7:0] pfn_of(input logic [19:0] vpn);
        return vpn[7:0] ^ 8'hA5;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic pulse(input bit is_flush);
        @(negedge clk);
        if (is_flush) flush = 1'b1; else clr_ref = 1'b1;
        @(negedge clk);
        flush = 1'b0; clr_ref = 1'b0;
    endtask

    // Lookup with refill-and-retry on a miss
    task automatic access(input logic [31:0] va, input logic wr, input logic exp_hit,
                          input logic exp_dirty, input string rq);
        logic first_hit;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        first_hit = resp_hit;
        check(rq, {31'd0, first_hit}, {31'd0, exp_hit});
        if (!first_hit) begin
            check("R2", {31'd0, resp_miss}, 32'd1);
            check("R2", {12'd0, refill_vpn}, {12'd0, va[31:12]});
            refill_valid = 1'b1; refill_present = 1'b1; refill_pfn = pfn_of(va[31:12]);
            @(negedge clk);
            refill_valid = 1'b0;
            check("R3", {30'd0, fault, refill_req}, 32'd0);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R3", {31'd0, resp_hit}, 32'd1);
        end
        check("R1", {12'd0, resp_paddr}, {12'd0, pfn_of(va[31:12]), va[11:0]});
        check("R4", {31'd0, resp_dirty}, {31'd0, exp_dirty});
    endtask

    // Expect a miss; optionally show lookups are ignored while waiting; refuse the refill
    task automatic probe_fault(input logic [31:0] va, input bit try_ignore,
                               input logic [31:0] other, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, {30'd0, resp_miss, refill_req}, 32'd3);
        if (try_ignore) begin
            req_valid = 1'b1; req_vaddr = other;
            @(negedge clk);
            req_valid = 1'b0;
            check("R2", {29'd0, resp_hit, resp_miss, refill_req}, 32'd1);
        end
        refill_valid = 1'b1; refill_present = 1'b0; refill_pfn = 8'hEE;
        @(negedge clk);
        refill_valid = 1'b0;
        check("R5", {30'd0, fault, refill_req}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        refill_valid = 1'b0; refill_present = 1'b0; refill_pfn = '0;
        clr_ref = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {28'd0, resp_hit, resp_miss, refill_req, fault}, 32'd0);
        rst_n = 1'b1;

        // R1 R3 R4: table of accesses (first entry also shows R11 empty after reset)
        for (int k = 0; k < NVEC; k++) begin
            access(VEC[k][34:3], VEC[k][2], VEC[k][1], VEC[k][0], "R1");
        end

        // R10: flush empties everything; R5: fault installs nothing
        pulse(1'b1);
        probe_fault(32'h0000_1000, 1'b0, 32'd0, "R10");
        probe_fault(32'h0000_1000, 1'b0, 32'd0, "R5");

        // R6: fill all 16 free slots, R12: capacity 16
        for (int v = 0; v < 16; v++) access({20'h00100 + 20'(v), 12'h000}, 1'b0, 1'b0, 1'b0, "R6");
        for (int v = 0; v < 16; v++) access({20'h00100 + 20'(v), 12'h004}, 1'b0, 1'b1, 1'b0, "R12");

        // R8: all referenced, round-robin from 0
        access(32'h0020_0000, 1'b0, 1'b0, 1'b0, "R8");
        access(32'h0020_1000, 1'b0, 1'b0, 1'b0, "R8");
        probe_fault(32'h0010_0000, 1'b1, 32'h0010_2000, "R8");
        probe_fault(32'h0010_1000, 1'b1, 32'h0010_2000, "R8");
        access(32'h0010_2000, 1'b0, 1'b1, 1'b0, "R8");

        // R9 R7: clear references, re-reference entry 0, next victim is entry 1
        pulse(1'b0);
        access(32'h0020_0000, 1'b0, 1'b1, 1'b0, "R9");
        access(32'h0020_2000, 1'b0, 1'b0, 1'b0, "R7");
        probe_fault(32'h0020_1000, 1'b0, 32'd0, "R7");
        access(32'h0020_0000, 1'b0, 1'b1, 1'b0, "R7");
        access(32'h0010_3000, 1'b1, 1'b1, 1'b1, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule